// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

This block is a synchronous static memory with one 32-bit data word split into four 8-bit byte lanes. The address, the write data and every control input are captured on the rising clock edge. A read loads the addressed word into an output register one clock after capture. A write updates the array on the clock edge that follows capture and needs no external write pulse. The depth is a parameter: the default of 10 address bits gives 1024 words, and 16 address bits give 65,536 words of 32 bits.

Writes can be masked at two levels. A global write input stores the whole word. If the global write is not asserted, a byte-write qualifier enables four per-lane enables. Three chip enables, two active-low and one active-high, let several of these memories share one bus for depth expansion. A sleep input powers the array down. It holds the array contents, and once sleep is released it refuses access for a fixed three-cycle wake-up period. An output enable does not drive pads here. It only qualifies the read-valid flag.

Top module: `pipe_burst_sram`

## Requirements
- R1: While reset is asserted and at the first edge after it is released, `rData` is zero and `rValid` is low.
- R2: A selected read with `gwN`=1 and `bweN`=1, captured at edge k, puts the addressed word on `rData` after edge k+1. With `oeN`=0, `rValid` is high in that cycle.
- R3: While `oeN` is high, `rValid` is low. `rData` still shows the word that was read.
- R4: A captured cycle with `gwN`=0 writes all 32 bits, whatever the values of `bweN` and `bwN`.
- R5: A captured cycle with `gwN`=1 and `bweN`=0 writes only the lanes whose `bwN` bit is 0. `bwN[0]` covers bits 7:0, `bwN[1]` bits 15:8, `bwN[2]` bits 23:16 and `bwN[3]` bits 31:24. The other lanes keep their old contents.
- R6: With `gwN`=1 and `bweN`=1 the cycle is a read, and the values on `bwN` have no effect.
- R7: A cycle is selected only when `ce1N`=0, `ce2`=1 and `ce3N`=0. An unselected cycle does not write, and `rValid` is low after the next edge.
- R8: A cycle captured while `sleep` is high is ignored. The array contents are kept through sleep.
- R9: After `sleep` returns low, the first three captured cycles are ignored. The fourth is accepted.
- R10: A read captured on the edge right after a write to the same address returns the newly written bytes.
- R11: A write cycle leaves `rValid` low after the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Active-low synchronous reset |
| addr | input | ADDR_W | Word address |
| wData | input | 32 | Write data |
| ce1N | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| ce3N | input | 1 | Chip enable, active low |
| gwN | input | 1 | Global write, active low, all lanes |
| bweN | input | 1 | Byte-write qualifier, active low |
| bwN | input | 4 | Per-lane write enables, active low |
| oeN | input | 1 | Output enable, qualifies rValid |
| sleep | input | 1 | Power-down request, active high |
| rData | output | 32 | Registered read data |
| rValid | output | 1 | Read data valid |

## Verification
The assertions assume that reset is held for at least one edge before the first real cycle. They also assume that the control inputs are at known levels at each edge, because a mask or a strobe computed from an X input has no meaning. The bench sets every input at the falling edge, keeps reset asserted for several cycles, and keeps `sleep` low during reset. Random addresses fall inside a 16-word window that is fully written before any random read, so every expected word comes from the bench's own model.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;
  localparam int LANE_W = 8;
  localparam int LANES  = 4;
  localparam int DATA_W = LANE_W * LANES;

  typedef struct packed {
    logic             wr;
    logic             rd;
    logic [LANES-1:0] mask;
  } sram_strobe_t;
endpackage

// File: rtl/burst_sram_ctrl.sv
module burst_sram_ctrl
  import burst_sram_pkg::*;
#(
  parameter int WAKE_CYCLES = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ce1N,
  input  logic             ce2,
  input  logic             ce3N,
  input  logic             gwN,
  input  logic             bweN,
  input  logic [LANES-1:0] bwN,
  input  logic             sleep,
  output sram_strobe_t     strobe
);
  localparam int CW = $clog2(WAKE_CYCLES + 1);

  logic [CW-1:0]    wakeCnt;
  logic             selected;
  logic             awake;
  logic             accept;
  logic             isWrite;
  logic [LANES-1:0] laneMask;

  always_ff @(posedge clk) begin
    if (!rstN)               wakeCnt <= '0;
    else if (sleep)          wakeCnt <= CW'(WAKE_CYCLES);
    else if (wakeCnt != '0)  wakeCnt <= wakeCnt - 1'b1;
  end

  always_comb begin
    selected = !ce1N && ce2 && !ce3N;
    awake    = !sleep && (wakeCnt == '0);
    accept   = selected && awake;
    isWrite  = !gwN || !bweN;
    if (!gwN)       laneMask = '1;
    else if (!bweN) laneMask = ~bwN;
    else            laneMask = '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      strobe <= '0;
    end else begin
      strobe.wr   <= accept && isWrite;
      strobe.rd   <= accept && !isWrite;
      strobe.mask <= (accept && isWrite) ? laneMask : '0;
    end
  end

  a_r7_deselect_ignored: assert property (@(posedge clk) disable iff (!rstN)
    !selected |=> !(strobe.wr || strobe.rd));

  a_r9_wake_lockout: assert property (@(posedge clk) disable iff (!rstN)
    (sleep || wakeCnt != '0) |=> (strobe == '0));
endmodule

// File: rtl/burst_sram_datapath.sv
module burst_sram_datapath
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wData,
  input  sram_strobe_t      strobe,
  output logic [DATA_W-1:0] rData,
  output logic              rdValid
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] dataQ;
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ <= '0;
      dataQ <= '0;
    end else begin
      addrQ <= addr;
      dataQ <= wData;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (strobe.wr && strobe.mask[g])
        mem[addrQ][g*LANE_W +: LANE_W] <= dataQ[g*LANE_W +: LANE_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rData   <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= strobe.rd;
      if (strobe.rd) rData <= mem[addrQ];
    end
  end

  a_r2_read_valid: assert property (@(posedge clk) disable iff (!rstN)
    strobe.rd |=> rdValid);

  a_r11_write_no_valid: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wr |=> !rdValid);

  a_r4_full_write: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wr && strobe.mask == '1) |=> (mem[$past(addrQ)] == $past(dataQ)));
endmodule

// File: rtl/pipe_burst_sram.sv
module pipe_burst_sram
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W      = 10,
  parameter int WAKE_CYCLES = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wData,
  input  logic              ce1N,
  input  logic              ce2,
  input  logic              ce3N,
  input  logic              gwN,
  input  logic              bweN,
  input  logic [LANES-1:0]  bwN,
  input  logic              oeN,
  input  logic              sleep,
  output logic [DATA_W-1:0] rData,
  output logic              rValid
);
  sram_strobe_t strobe;
  logic         rdValid;

  burst_sram_ctrl #(.WAKE_CYCLES(WAKE_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .ce1N(ce1N), .ce2(ce2), .ce3N(ce3N),
    .gwN(gwN), .bweN(bweN), .bwN(bwN), .sleep(sleep), .strobe(strobe)
  );

  burst_sram_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .addr(addr), .wData(wData), .strobe(strobe),
    .rData(rData), .rdValid(rdValid)
  );

  assign rValid = rdValid && !oeN;

  a_r3_oe_gates_valid: assert property (@(posedge clk) disable iff (!rstN)
    oeN |-> !rValid);
endmodule

// File: tb/pipe_burst_sram_bench.sv
module pipe_burst_sram_bench;
  localparam int AW = 10;

  logic          clk = 1'b0;
  logic          rstN;
  logic [AW-1:0] addr;
  logic [31:0]   wData;
  logic          ce1N, ce2, ce3N, gwN, bweN, oeN, sleep;
  logic [3:0]    bwN;
  logic [31:0]   rData;
  logic          rValid;

  int checks = 0;
  int fails  = 0;
  logic [31:0] model [16];

  always #5 clk = ~clk;

  pipe_burst_sram #(.ADDR_W(AW)) u_pipe_burst_sram (
    .clk(clk), .rstN(rstN), .addr(addr), .wData(wData), .ce1N(ce1N), .ce2(ce2),
    .ce3N(ce3N), .gwN(gwN), .bweN(bweN), .bwN(bwN), .oeN(oeN), .sleep(sleep),
    .rData(rData), .rValid(rValid)
  );

  function automatic logic [3:0] laneMaskOf(logic g, logic b, logic [3:0] bw);
    if (!g) return 4'hF;
    if (!b) return ~bw;
    return 4'h0;
  endfunction

  function automatic logic [31:0] merge(logic [31:0] old, logic [31:0] nw, logic [3:0] m);
    logic [31:0] r = old;
    for (int i = 0; i < 4; i++) if (m[i]) r[i*8 +: 8] = nw[i*8 +: 8];
    return r;
  endfunction

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic drive(logic [AW-1:0] a, logic [31:0] d, logic g, logic b, logic [3:0] bw);
    ce1N = 1'b0; ce2 = 1'b1; ce3N = 1'b0;
    addr = a; wData = d; gwN = g; bweN = b; bwN = bw;
  endtask

  task automatic idle();
    ce1N = 1'b1; gwN = 1'b1; bweN = 1'b1; bwN = 4'hF;
  endtask

  task automatic doWrite(logic [AW-1:0] a, logic [31:0] d, logic g, logic b, logic [3:0] bw);
    drive(a, d, g, b, bw);
    if (a < 16) model[a[3:0]] = merge(model[a[3:0]], d, laneMaskOf(g, b, bw));
    step();
    idle();
    step();
    chk("R11 write leaves rValid low", {31'd0, rValid}, 32'd0);
  endtask

  task automatic doRead(string tag, logic [AW-1:0] a, logic [3:0] bw);
    drive(a, 32'hDEAD_BEEF, 1'b1, 1'b1, bw);
    step();
    idle();
    step();
    chk({tag, " data"}, rData, model[a[3:0]]);
    chk({tag, " valid"}, {31'd0, rValid}, {31'd0, !oeN});
  endtask

  initial begin
    #2_000_000;
    fails++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    rstN = 1'b0; sleep = 1'b0; oeN = 1'b0; addr = '0; wData = '0;
    ce2 = 1'b1; ce3N = 1'b0;
    idle();
    repeat (4) step();
    chk("R1 reset data", rData, 32'd0);
    chk("R1 reset valid", {31'd0, rValid}, 32'd0);
    rstN = 1'b1;
    step();
    chk("R1 after release data", rData, 32'd0);
    chk("R1 after release valid", {31'd0, rValid}, 32'd0);

    for (int i = 0; i < 16; i++) doWrite(AW'(i), $urandom, 1'b0, 1'b1, 4'hF);
    doRead("R2 basic read", 10'd3, 4'hF);

    // R4: global write overrides the lane enables
    doWrite(10'd1, 32'hA1B2C3D4, 1'b0, 1'b0, 4'hF);
    doRead("R4 global write", 10'd1, 4'hF);

    // R5: lanes 0 and 2 written
    doWrite(10'd2, 32'h11223344, 1'b0, 1'b1, 4'hF);
    doWrite(10'd2, 32'hAABBCCDD, 1'b1, 1'b0, 4'b1010);
    chk("R5 lane mask model", model[2], 32'h11BB33DD);
    doRead("R5 byte write", 10'd2, 4'hF);

    // R6: bweN high makes bwN irrelevant
    doRead("R6 read with bwN low", 10'd2, 4'h0);

    // R3: oeN high
    oeN = 1'b1;
    doRead("R3 oe high", 10'd1, 4'hF);
    oeN = 1'b0;

    // R10: write then read the same address on consecutive edges
    drive(10'd7, 32'h5A5A_0F0F, 1'b0, 1'b1, 4'hF);
    model[7] = 32'h5A5A_0F0F;
    step();
    drive(10'd7, 32'h0, 1'b1, 1'b1, 4'hF);
    step();
    idle();
    step();
    chk("R10 back-to-back data", rData, 32'h5A5A_0F0F);
    chk("R10 back-to-back valid", {31'd0, rValid}, 32'd1);

    // R7: each chip enable alone deselects
    for (int k = 0; k < 3; k++) begin
      drive(10'd7, 32'hFFFF_FFFF, 1'b0, 1'b1, 4'hF);
      if (k == 0) ce1N = 1'b1;
      if (k == 1) ce2  = 1'b0;
      if (k == 2) ce3N = 1'b1;
      step();
      drive(10'd7, 32'h0, 1'b1, 1'b1, 4'hF);
      if (k == 0) ce1N = 1'b1;
      if (k == 1) ce2  = 1'b0;
      if (k == 2) ce3N = 1'b1;
      step();
      idle(); ce2 = 1'b1; ce3N = 1'b0;
      step();
      chk("R7 deselected read valid", {31'd0, rValid}, 32'd0);
      doRead("R7 deselected write ignored", 10'd7, 4'hF);
    end

    // R8 / R9: sleep, then wake-up lockout
    sleep = 1'b1;
    drive(10'd5, 32'hCAFE_F00D, 1'b0, 1'b1, 4'hF);
    step();
    step();
    drive(10'd5, 32'h0, 1'b1, 1'b1, 4'hF);
    step();
    chk("R8 read while asleep", {31'd0, rValid}, 32'd0);
    sleep = 1'b0;
    step();
    step();
    chk("R9 lockout cycle 1", {31'd0, rValid}, 32'd0);
    step();
    chk("R9 lockout cycle 2", {31'd0, rValid}, 32'd0);
    step();
    chk("R9 lockout cycle 3", {31'd0, rValid}, 32'd0);
    idle();
    step();
    chk("R9 fourth cycle accepted", {31'd0, rValid}, 32'd1);
    chk("R8 contents kept", rData, model[5]);

    // random mix
    for (int n = 0; n < 400; n++) begin
      logic [AW-1:0] a;
      int kind;
      a = AW'($urandom % 16);
      kind = $urandom % 4;
      case (kind)
        0: doWrite(a, $urandom, 1'b0, 1'($urandom), 4'($urandom));
        1: doWrite(a, $urandom, 1'b1, 1'b0, 4'($urandom));
        2: doRead("R2 random read", a, 4'($urandom));
        default: begin
          oeN = 1'b1;
          doRead("R3 random oe high", a, 4'hF);
          oeN = 1'b0;
        end
      endcase
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule